// File: doc/BRIEF.md
# Anode-Cathode Segment Time Matcher

A chamber reports, on every bunch crossing, up to two segments measured by its anode wires and up to two measured by its cathode strips. Each segment carries a position key and a count of the layers that fired. This block pairs anode segments with cathode segments whose arrival crossings fall close enough together. It then emits up to two matched two-dimensional stubs per crossing for a downstream sorter.

Anode segments wait in a short pipeline. Each cathode segment is delayed to the centre of a programmable acceptance window, so that anode segments arriving before it and after it can both be considered. When one view has two segments and the other has one, the lone segment is shared by both stubs. When both views have two, the segments with more layers go together. An anode segment is used only once. Any segment left without a partner is discarded when it ages out of the window.

The block also contains a small capture engine for readout. When the block is idle and a segment arrives, it streams a 16-crossing record of the input valid bits and the stub valid bits. The record starts a programmable number of crossings before the triggering crossing.

Top module: `seg_time_matcher`

## Requirements
- R1: After reset, both stub slots are invalid and readValid and readFirst are low.
- R2: Take one anode segment and one cathode segment that are accepted together, with the cathode sampled at clock edge t. Exactly one stub appears on slot 0 after edge t+4 and slot 1 stays invalid. The stub carries both keys and quality = anode layers + cathode layers.
- R3: Let W be matchWindow, with 0 treated as 1. Let lo = floor(W/2) and hi = W-1-lo. An anode segment sampled d crossings after a cathode segment is accepted only when -lo <= d <= hi.
- R4: With two anode segments and one cathode segment accepted together, two stubs are emitted and both carry the single cathode segment.
- R5: With one anode segment and two cathode segments, two stubs are emitted and both carry the single anode segment.
- R6: With two of each, the anode segment with more layers is paired with the cathode segment with more layers, and the remaining two are paired. On equal layer counts, the first-selected anode segment or slot-0 cathode segment counts as the larger.
- R7: Two valid stubs leave in descending quality order. On equal quality, selection order is kept.
- R8: Anode candidates are taken oldest crossing first, and slot 0 before slot 1 within a crossing, up to two at a time. A matched anode segment is consumed and never paired again. An anode segment older than 6 crossings is discarded.
- R9: A segment with no partner in the window never produces a stub.
- R10: While idle, any input segment valid at crossing T starts a capture. readValid is high for the 16 cycles after edge T, and readFirst marks only the first of them. The words cover crossings T-P through T-P+15, where P is capturePre clamped to 2..5. Segments arriving during a capture neither restart nor extend it.
- R11: A readWord holds, for its crossing, anode valid bits in [5:4] and cathode valid bits in [3:2]. Bits [1:0] hold the stub valid bits presented during that crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rstN | input | 1 | Active-low asynchronous reset |
| matchWindow | input | 3 | Acceptance window width in crossings (1..7) |
| capturePre | input | 3 | Capture lead in crossings (clamped to 2..5) |
| anodeValid | input | 2 | Anode segment valid, one bit per slot |
| anodeKey | input | 14 | Anode keys, slot s at [7s+6:7s] |
| anodeLayers | input | 6 | Anode layer counts, slot s at [3s+2:3s] |
| cathodeValid | input | 2 | Cathode segment valid, one bit per slot |
| cathodeKey | input | 16 | Cathode keys, slot s at [8s+7:8s] |
| cathodeLayers | input | 6 | Cathode layer counts, slot s at [3s+2:3s] |
| stubValid | output | 2 | Matched stub valid per slot |
| stubAnodeKey | output | 14 | Anode key of each stub |
| stubCathodeKey | output | 16 | Cathode key of each stub |
| stubQuality | output | 8 | Quality of each stub, slot s at [4s+3:4s] |
| readValid | output | 1 | Capture word valid |
| readFirst | output | 1 | First word of a capture |
| readWord | output | 6 | Capture record word |

## Verification
The bench sweeps every window setting against anode offsets from four crossings early to four late. An off-by-one in the window edges or in the cathode centring delay would accept a pair just outside the window or reject one at its edge. Directed cases cover the copy cases, pairing by layer count with ties, and quality ordering. A swapped pairing or an unstable sort shows up as exchanged keys between the two slots. A three-anode case catches a matcher that reuses a consumed segment or selects the wrong anode segment first. The capture is swept over every lead setting, including out-of-range values. A wrong tap or a restart on a later hit shows up as shifted words or a stretched readValid.

// File: rtl/segmatch_pkg.sv
package segmatch_pkg;
  localparam int ANODE_KEY_W   = 7;
  localparam int CATHODE_KEY_W = 8;
  localparam int LAYER_W       = 3;
  localparam int QUAL_W        = LAYER_W + 1;
  localparam int SEG_SLOTS     = 2;
  localparam int MAX_HALF      = 3;
  localparam int MATCH_DEPTH   = 2 * MAX_HALF + 1;
  localparam int STAGE_W       = $clog2(MATCH_DEPTH);
  localparam int WIN_W         = $clog2(MATCH_DEPTH + 1);
  localparam int PRE_MIN       = 2;
  localparam int PRE_MAX       = 5;
  localparam int TAP_W         = $clog2(PRE_MAX + 1);
  localparam int CAPTURE_LEN   = 16;
  localparam int CNT_W         = $clog2(CAPTURE_LEN);
  localparam int REC_W         = 3 * SEG_SLOTS;

  typedef struct packed {
    logic                     valid;
    logic [ANODE_KEY_W-1:0]   key;
    logic [LAYER_W-1:0]       layers;
  } anodeSeg_t;

  typedef struct packed {
    logic                     valid;
    logic [CATHODE_KEY_W-1:0] key;
    logic [LAYER_W-1:0]       layers;
  } cathodeSeg_t;

  typedef struct packed {
    logic                     valid;
    logic [ANODE_KEY_W-1:0]   anodeKey;
    logic [CATHODE_KEY_W-1:0] cathodeKey;
    logic [QUAL_W-1:0]        quality;
  } stub_t;

  typedef struct packed {
    logic [MATCH_DEPTH-1:0]   windowMask;
    logic [TAP_W-1:0]         recordTap;
  } match_strobe_t;

  function automatic logic [QUAL_W-1:0] qualOf(input logic [LAYER_W-1:0] a,
                                               input logic [LAYER_W-1:0] c);
    return QUAL_W'(a) + QUAL_W'(c);
  endfunction
endpackage

// File: rtl/segmatch_control.sv
module segmatch_control
  import segmatch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIN_W-1:0] matchWindow,
  input  logic [TAP_W-1:0] capturePre,
  input  logic             anyHit,
  output match_strobe_t    strobes,
  output logic             readValid,
  output logic             readFirst
);
  logic [MATCH_DEPTH-1:0] windowMask;
  logic [TAP_W-1:0]       preEff;
  logic [TAP_W-1:0]       tapReg;
  logic [CNT_W-1:0]       cnt;
  logic                   busy;

  // Window decode: stage k holds anodes aged k; centre stage sits at MAX_HALF
  always_comb begin
    int wEff, lo, hi;
    wEff = int'(matchWindow);
    if (wEff < 1) wEff = 1;
    if (wEff > MATCH_DEPTH) wEff = MATCH_DEPTH;
    lo = wEff / 2;
    hi = wEff - 1 - lo;
    for (int k = 0; k < MATCH_DEPTH; k++)
      windowMask[k] = (k >= MAX_HALF - hi) && (k <= MAX_HALF + lo);
  end

  always_comb begin
    preEff = capturePre;
    if (capturePre < TAP_W'(PRE_MIN)) preEff = TAP_W'(PRE_MIN);
    if (capturePre > TAP_W'(PRE_MAX)) preEff = TAP_W'(PRE_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      tapReg <= TAP_W'(PRE_MIN);
    end else if (!busy) begin
      if (anyHit) begin
        busy   <= 1'b1;
        cnt    <= '0;
        tapReg <= preEff;
      end
    end else if (cnt == CNT_W'(CAPTURE_LEN - 1)) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strobes   = '{windowMask: windowMask, recordTap: tapReg};
  assign readValid = busy;
  assign readFirst = busy && (cnt == '0);

  assert_trigger_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readValid) |-> $past(anyHit));
  assert_first_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    readFirst |=> !readFirst);
  assert_capture_span_R10: assert property (@(posedge clk) disable iff (!rstN)
    (readValid && cnt == CNT_W'(CAPTURE_LEN - 1)) |=> !readValid);
endmodule

// File: rtl/segmatch_datapath.sv
module segmatch_datapath
  import segmatch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  match_strobe_t      strobes,
  input  anodeSeg_t          anodeIn   [SEG_SLOTS],
  input  cathodeSeg_t        cathodeIn [SEG_SLOTS],
  output stub_t              stubOut   [SEG_SLOTS],
  output logic [REC_W-1:0]   recordOut
);
  anodeSeg_t   anodePipe [MATCH_DEPTH][SEG_SLOTS];
  cathodeSeg_t cathDly   [MAX_HALF+1][SEG_SLOTS];
  logic [REC_W-1:0] recDly [PRE_MAX+1];
  stub_t       stubReg   [SEG_SLOTS];

  anodeSeg_t   selA0, selA1, pairA0, pairA1;
  cathodeSeg_t selC0, selC1, pairC0, pairC1;
  logic [STAGE_W-1:0] selK0, selK1;
  logic        selS0, selS1;
  logic [1:0]  nA, nC;
  logic        matched, pairTwo;
  stub_t       cand0, cand1, sort0, sort1;
  logic        consume [MATCH_DEPTH][SEG_SLOTS];
  logic        consumeBad;

  // Anode candidate selection: oldest stage first, slot 0 before slot 1
  always_comb begin
    nA = 2'd0;
    selA0 = '0; selA1 = '0;
    selK0 = '0; selK1 = '0;
    selS0 = 1'b0; selS1 = 1'b0;
    for (int k = MATCH_DEPTH - 1; k >= 0; k--) begin
      for (int s = 0; s < SEG_SLOTS; s++) begin
        if (strobes.windowMask[k] && anodePipe[k][s].valid) begin
          if (nA == 2'd0) begin
            selA0 = anodePipe[k][s]; selK0 = STAGE_W'(k); selS0 = 1'(s); nA = 2'd1;
          end else if (nA == 2'd1) begin
            selA1 = anodePipe[k][s]; selK1 = STAGE_W'(k); selS1 = 1'(s); nA = 2'd2;
          end
        end
      end
    end
  end

  // Centred cathode view
  always_comb begin
    nC    = {1'b0, cathDly[MAX_HALF][0].valid} + {1'b0, cathDly[MAX_HALF][1].valid};
    selC0 = cathDly[MAX_HALF][0].valid ? cathDly[MAX_HALF][0] : cathDly[MAX_HALF][1];
    selC1 = cathDly[MAX_HALF][1];
  end

  assign matched = (nA != 2'd0) && (nC != 2'd0);

  // Pairing: copy the lone segment, or pair by layer count when both views have two
  always_comb begin
    logic aSwap, cSwap;
    aSwap = 1'b0; cSwap = 1'b0;
    if (nA == 2'd2 && nC == 2'd2) begin
      aSwap  = selA1.layers > selA0.layers;
      cSwap  = selC1.layers > selC0.layers;
      pairA0 = aSwap ? selA1 : selA0;
      pairA1 = aSwap ? selA0 : selA1;
      pairC0 = cSwap ? selC1 : selC0;
      pairC1 = cSwap ? selC0 : selC1;
      pairTwo = 1'b1;
    end else begin
      pairA0 = selA0;
      pairC0 = selC0;
      pairA1 = (nA == 2'd2) ? selA1 : selA0;
      pairC1 = (nC == 2'd2) ? selC1 : selC0;
      pairTwo = (nA == 2'd2) || (nC == 2'd2);
    end
    cand0 = '{valid: matched, anodeKey: pairA0.key, cathodeKey: pairC0.key,
              quality: qualOf(pairA0.layers, pairC0.layers)};
    cand1 = '{valid: matched && pairTwo, anodeKey: pairA1.key, cathodeKey: pairC1.key,
              quality: qualOf(pairA1.layers, pairC1.layers)};
    if (cand1.valid && (cand1.quality > cand0.quality)) begin
      sort0 = cand1; sort1 = cand0;
    end else begin
      sort0 = cand0; sort1 = cand1;
    end
  end

  // Consumption of matched anodes
  always_comb begin
    consumeBad = 1'b0;
    for (int k = 0; k < MATCH_DEPTH; k++) begin
      for (int s = 0; s < SEG_SLOTS; s++) begin
        consume[k][s] = matched &&
          ((selK0 == STAGE_W'(k) && selS0 == 1'(s)) ||
           (nA == 2'd2 && selK1 == STAGE_W'(k) && selS1 == 1'(s)));
        if (consume[k][s] && !anodePipe[k][s].valid) consumeBad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < MATCH_DEPTH; k++)
        for (int s = 0; s < SEG_SLOTS; s++) anodePipe[k][s] <= '0;
      for (int k = 0; k <= MAX_HALF; k++)
        for (int s = 0; s < SEG_SLOTS; s++) cathDly[k][s] <= '0;
      for (int k = 0; k <= PRE_MAX; k++) recDly[k] <= '0;
      for (int s = 0; s < SEG_SLOTS; s++) stubReg[s] <= '0;
    end else begin
      for (int s = 0; s < SEG_SLOTS; s++) begin
        anodePipe[0][s] <= anodeIn[s];
        cathDly[0][s]   <= cathodeIn[s];
        for (int k = 1; k < MATCH_DEPTH; k++) begin
          anodePipe[k][s]       <= anodePipe[k-1][s];
          anodePipe[k][s].valid <= anodePipe[k-1][s].valid && !consume[k-1][s];
        end
        for (int k = 1; k <= MAX_HALF; k++) cathDly[k][s] <= cathDly[k-1][s];
      end
      recDly[0] <= {anodeIn[1].valid, anodeIn[0].valid,
                    cathodeIn[1].valid, cathodeIn[0].valid,
                    stubReg[1].valid, stubReg[0].valid};
      for (int k = 1; k <= PRE_MAX; k++) recDly[k] <= recDly[k-1];
      stubReg[0] <= sort0;
      stubReg[1] <= sort1;
    end
  end

  assign stubOut   = stubReg;
  assign recordOut = recDly[strobes.recordTap];

  assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    stubReg[1].valid |-> stubReg[0].valid);
  assert_quality_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stubReg[0].valid && stubReg[1].valid) |-> (stubReg[0].quality >= stubReg[1].quality));
  assert_needs_cathode_R9: assert property (@(posedge clk) disable iff (!rstN)
    stubReg[0].valid |-> $past(cathDly[MAX_HALF][0].valid || cathDly[MAX_HALF][1].valid));
  assert_consume_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !consumeBad);
endmodule

// File: rtl/seg_time_matcher.sv
module seg_time_matcher
  import segmatch_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [WIN_W-1:0]                  matchWindow,
  input  logic [TAP_W-1:0]                  capturePre,
  input  logic [SEG_SLOTS-1:0]              anodeValid,
  input  logic [SEG_SLOTS*ANODE_KEY_W-1:0]  anodeKey,
  input  logic [SEG_SLOTS*LAYER_W-1:0]      anodeLayers,
  input  logic [SEG_SLOTS-1:0]              cathodeValid,
  input  logic [SEG_SLOTS*CATHODE_KEY_W-1:0] cathodeKey,
  input  logic [SEG_SLOTS*LAYER_W-1:0]      cathodeLayers,
  output logic [SEG_SLOTS-1:0]              stubValid,
  output logic [SEG_SLOTS*ANODE_KEY_W-1:0]  stubAnodeKey,
  output logic [SEG_SLOTS*CATHODE_KEY_W-1:0] stubCathodeKey,
  output logic [SEG_SLOTS*QUAL_W-1:0]       stubQuality,
  output logic                              readValid,
  output logic                              readFirst,
  output logic [REC_W-1:0]                  readWord
);
  anodeSeg_t     anodeIn   [SEG_SLOTS];
  cathodeSeg_t   cathodeIn [SEG_SLOTS];
  stub_t         stubOut   [SEG_SLOTS];
  match_strobe_t strobes;

  for (genvar s = 0; s < SEG_SLOTS; s++) begin : gSlot
    assign anodeIn[s]   = '{valid: anodeValid[s],
                            key: anodeKey[s*ANODE_KEY_W +: ANODE_KEY_W],
                            layers: anodeLayers[s*LAYER_W +: LAYER_W]};
    assign cathodeIn[s] = '{valid: cathodeValid[s],
                            key: cathodeKey[s*CATHODE_KEY_W +: CATHODE_KEY_W],
                            layers: cathodeLayers[s*LAYER_W +: LAYER_W]};
    assign stubValid[s] = stubOut[s].valid;
    assign stubAnodeKey[s*ANODE_KEY_W +: ANODE_KEY_W]       = stubOut[s].anodeKey;
    assign stubCathodeKey[s*CATHODE_KEY_W +: CATHODE_KEY_W] = stubOut[s].cathodeKey;
    assign stubQuality[s*QUAL_W +: QUAL_W]                  = stubOut[s].quality;
  end

  segmatch_control ctrl_i (
    .clk(clk), .rstN(rstN), .matchWindow(matchWindow), .capturePre(capturePre),
    .anyHit(|{anodeValid, cathodeValid}), .strobes(strobes),
    .readValid(readValid), .readFirst(readFirst)
  );

  segmatch_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .anodeIn(anodeIn),
    .cathodeIn(cathodeIn), .stubOut(stubOut), .recordOut(readWord)
  );
endmodule

// File: tb/seg_time_matcher_tb_top.sv
module seg_time_matcher_tb_top;
  import segmatch_pkg::*;
  localparam int LEN = 30;
  localparam int AK = ANODE_KEY_W, CK = CATHODE_KEY_W, LW = LAYER_W, QW = QUAL_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic [WIN_W-1:0] matchWindow = '0;
  logic [TAP_W-1:0] capturePre = '0;
  logic [1:0] anodeValid = '0, cathodeValid = '0;
  logic [2*AK-1:0] anodeKey = '0;
  logic [2*CK-1:0] cathodeKey = '0;
  logic [2*LW-1:0] anodeLayers = '0, cathodeLayers = '0;
  logic [1:0] stubValid;
  logic [2*AK-1:0] stubAnodeKey;
  logic [2*CK-1:0] stubCathodeKey;
  logic [2*QW-1:0] stubQuality;
  logic readValid, readFirst;
  logic [REC_W-1:0] readWord;

  int checks = 0, failures = 0;

  logic [1:0] sAV [LEN], sCV [LEN];
  logic [AK-1:0] sAK [LEN][2];
  logic [CK-1:0] sCK [LEN][2];
  logic [LW-1:0] sAL [LEN][2], sCL [LEN][2];
  logic [1:0] oSV [LEN];
  logic [AK-1:0] oAK [LEN][2];
  logic [CK-1:0] oCK [LEN][2];
  logic [QW-1:0] oQ [LEN][2];
  logic oRV [LEN], oRF [LEN];
  logic [REC_W-1:0] oRW [LEN];

  seg_time_matcher dut_i (
    .clk(clk), .rstN(rstN), .matchWindow(matchWindow), .capturePre(capturePre),
    .anodeValid(anodeValid), .anodeKey(anodeKey), .anodeLayers(anodeLayers),
    .cathodeValid(cathodeValid), .cathodeKey(cathodeKey), .cathodeLayers(cathodeLayers),
    .stubValid(stubValid), .stubAnodeKey(stubAnodeKey), .stubCathodeKey(stubCathodeKey),
    .stubQuality(stubQuality), .readValid(readValid), .readFirst(readFirst),
    .readWord(readWord)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearSched();
    for (int i = 0; i < LEN; i++) begin
      sAV[i] = '0; sCV[i] = '0;
      for (int s = 0; s < 2; s++) begin
        sAK[i][s] = '0; sCK[i][s] = '0; sAL[i][s] = '0; sCL[i][s] = '0;
      end
    end
  endtask

  task automatic putA(input int i, input int s, input int key, input int lay);
    sAV[i][s] = 1'b1; sAK[i][s] = AK'(key); sAL[i][s] = LW'(lay);
  endtask

  task automatic putC(input int i, input int s, input int key, input int lay);
    sCV[i][s] = 1'b1; sCK[i][s] = CK'(key); sCL[i][s] = LW'(lay);
  endtask

  task automatic runSched(input int w, input int p);
    matchWindow = WIN_W'(w);
    capturePre  = TAP_W'(p);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      oSV[i] = stubValid; oRV[i] = readValid; oRF[i] = readFirst; oRW[i] = readWord;
      for (int s = 0; s < 2; s++) begin
        oAK[i][s] = stubAnodeKey[s*AK +: AK];
        oCK[i][s] = stubCathodeKey[s*CK +: CK];
        oQ[i][s]  = stubQuality[s*QW +: QW];
      end
      anodeValid    = sAV[i];
      anodeKey      = {sAK[i][1], sAK[i][0]};
      anodeLayers   = {sAL[i][1], sAL[i][0]};
      cathodeValid  = sCV[i];
      cathodeKey    = {sCK[i][1], sCK[i][0]};
      cathodeLayers = {sCL[i][1], sCL[i][0]};
    end
    @(negedge clk);
    anodeValid = '0; cathodeValid = '0;
  endtask

  task automatic expStub(input int i, input int s, input bit v, input int ak, input int ck,
                         input int q, input string req);
    chk(req, $sformatf("valid idx%0d slot%0d", i, s), oSV[i][s], v);
    if (v) begin
      chk(req, $sformatf("anodeKey idx%0d slot%0d", i, s), oAK[i][s], ak);
      chk(req, $sformatf("cathodeKey idx%0d slot%0d", i, s), oCK[i][s], ck);
      chk(req, $sformatf("quality idx%0d slot%0d", i, s), oQ[i][s], q);
    end
  endtask

  function automatic int stubTotal();
    int n = 0;
    for (int i = 0; i < LEN; i++) n += int'(oSV[i][0]) + int'(oSV[i][1]);
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "stubValid in reset", stubValid, 0);
    chk("R1", "readValid in reset", readValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "stubValid after reset", stubValid, 0);
    chk("R1", "readFirst after reset", readFirst, 0);

    // R2, R3, R9: window sweep over settings and anode offsets
    for (int w = 0; w < 8; w++) begin
      for (int d = -4; d <= 4; d++) begin
        int we, lo, hi;
        bit inWin;
        we = (w == 0) ? 1 : w;
        lo = we / 2; hi = we - 1 - lo;
        inWin = (d >= -lo) && (d <= hi);
        clearSched();
        putA(8 + d, (w + d) & 1, 20 + d + 4, 4);
        putC(8, w & 1, 100 + w, 5);
        runSched(w, 3);
        expStub(13, 0, inWin, 20 + d + 4, 100 + w, 9, $sformatf("R2 R3 w%0d d%0d", w, d));
        chk("R2 R9", $sformatf("total stubs w%0d d%0d", w, d), stubTotal(), inWin ? 1 : 0);
      end
    end

    // R4: two anodes, one cathode, distinct quality
    clearSched(); putA(8, 0, 10, 3); putA(8, 1, 11, 6); putC(8, 0, 50, 5);
    runSched(1, 2);
    expStub(13, 0, 1, 11, 50, 11, "R4 R7");
    expStub(13, 1, 1, 10, 50, 8, "R4 R7");

    // R4, R7: equal quality keeps selection order
    clearSched(); putA(8, 0, 12, 4); putA(8, 1, 13, 4); putC(8, 0, 51, 4);
    runSched(1, 2);
    expStub(13, 0, 1, 12, 51, 8, "R4 R7 tie");
    expStub(13, 1, 1, 13, 51, 8, "R4 R7 tie");

    // R5: one anode, two cathodes
    clearSched(); putA(8, 1, 14, 5); putC(8, 0, 52, 4); putC(8, 1, 53, 6);
    runSched(1, 2);
    expStub(13, 0, 1, 14, 53, 11, "R5");
    expStub(13, 1, 1, 14, 52, 9, "R5");

    // R6: two of each, both orientations
    clearSched(); putA(8, 0, 20, 3); putA(8, 1, 21, 6); putC(8, 0, 60, 5); putC(8, 1, 61, 4);
    runSched(1, 2);
    expStub(13, 0, 1, 21, 60, 11, "R6 a");
    expStub(13, 1, 1, 20, 61, 7, "R6 a");
    clearSched(); putA(8, 0, 22, 5); putA(8, 1, 23, 4); putC(8, 0, 62, 3); putC(8, 1, 63, 6);
    runSched(1, 2);
    expStub(13, 0, 1, 22, 63, 11, "R6 b");
    expStub(13, 1, 1, 23, 62, 7, "R6 b");

    // R8: oldest-first selection, consumption, leftover used by next cathode
    clearSched(); putA(7, 1, 30, 5); putA(8, 0, 31, 5); putA(8, 1, 32, 3);
    putC(8, 0, 70, 4); putC(9, 1, 71, 4);
    runSched(3, 2);
    expStub(13, 0, 1, 30, 70, 9, "R8 oldest");
    expStub(13, 1, 1, 31, 70, 9, "R8 oldest");
    expStub(14, 0, 1, 32, 71, 7, "R8 leftover");
    expStub(14, 1, 0, 0, 0, 0, "R8 leftover");

    // R8: consumed anode not reused
    clearSched(); putA(8, 0, 33, 4); putC(8, 0, 72, 4); putC(9, 0, 73, 4);
    runSched(3, 2);
    expStub(13, 0, 1, 33, 72, 8, "R8 consume");
    expStub(14, 0, 0, 0, 0, 0, "R8 consume");
    chk("R8", "total stubs consume", stubTotal(), 1);

    // R9: lone segments beyond the widest window
    clearSched(); putC(6, 0, 74, 6); putA(11, 1, 34, 6);
    runSched(7, 2);
    chk("R9", "total stubs lone", stubTotal(), 0);

    // R10, R11: capture sweep over lead settings
    for (int p = 0; p < 8; p++) begin
      int pe;
      pe = (p < 2) ? 2 : (p > 5) ? 5 : p;
      clearSched(); putA(8, 0, 40, 4); putC(8, 1, 80, 4); putC(15, 0, 81, 4);
      runSched(1, p);
      expStub(13, 0, 1, 40, 80, 8, "R11 capture stub");
      for (int i = 0; i < LEN; i++) begin
        bit ev, ef;
        ev = (i >= 9) && (i <= 24);
        ef = (i == 9);
        chk("R10", $sformatf("readValid p%0d idx%0d", p, i), oRV[i], ev);
        chk("R10", $sformatf("readFirst p%0d idx%0d", p, i), oRF[i], ef);
        if (ev) begin
          int t;
          logic [5:0] ew;
          t = 8 - pe + (i - 9);
          ew = {(t == 8) ? 2'b01 : 2'b00,
                (t == 8) ? 2'b10 : (t == 15) ? 2'b01 : 2'b00,
                (t == 13) ? 2'b01 : 2'b00};
          chk("R11", $sformatf("readWord p%0d idx%0d", p, i), oRW[i], ew);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule